// File: doc/BRIEF.md
# DMA Descriptor Chain Sequencer

This block runs one DMA channel in linked-list mode. When started, it reads a four-word descriptor from memory through a simple read port. It hands the segment described there to an external copy engine and waits for that engine to report completion. It then follows the link held in the descriptor to the next one. The walk stops at a descriptor whose end-of-transfer bit is set.

At that point the sequencer goes idle and raises its completion flag. A later continue pulse resumes the walk from the link address of the last descriptor. Software can therefore append descriptors to a finished chain and restart it without reprogramming the start address.

A fetch error aborts the chain and raises a memory-error flag. While the channel is configured for direct (non-chained) transfers, this block ignores start and continue entirely. The data movement itself is done elsewhere.

Top module: `dma_chain_seq`

## Requirements
- R1: A start pulse accepted while idle raises busy_o and reads four words at B, B+0x08, B+0x10 and B+0x18, where B is cda_i with bits 4:0 forced to zero. After reset, busy_o, rd_req_o, seg_valid_o and all flags are low.
- R2: The four words are, in order, source address, destination address, link word and byte count. The segment presents src and dst unchanged, seg_len_o = count bits 25:0, seg_kind_o = link bits 2:1 and seg_snoop_o = link bit 4. seg_valid_o and the segment fields hold steady until seg_done_i.
- R3: Link bit 0 clear makes the sequencer fetch the next descriptor at link bits 31:5 (low five address bits zero). Link bit 0 set ends the chain: eoc_o goes high, busy_o goes low and the block returns to idle.
- R4: When a segment completes and its link bit 3 is set, eos_o is set. When bit 3 is clear, completing the segment leaves eos_o unchanged.
- R5: A descriptor whose 26-bit count is zero raises no segment. The chain carries on, or ends if that descriptor's link bit 0 is set.
- R6: A read returned with rd_err_i sets lme_o, stops all further reads, drops busy_o and leaves eoc_o low.
- R7: A continue pulse accepted while idle fetches from the link address held in the most recently fetched descriptor.
- R8: While direct_i is high, start and continue pulses are ignored: busy_o stays low, no read is issued and the flags keep their values.
- R9: eos_o, eoc_o and lme_o are sticky. They are cleared only when a start or continue is accepted.
- R10: rd_req_o stays high with rd_addr_o unchanged until rd_valid_i completes the read, and each completed read counts once.
- R11: Start and continue pulses arriving while busy_o is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a chain at cda_i |
| cont_i | input | 1 | Resume at the last descriptor's link |
| direct_i | input | 1 | Channel in direct mode; chaining disabled |
| cda_i | input | 32 | First descriptor address (bits 31:5 used) |
| rd_req_o | output | 1 | Read request, held until completed |
| rd_addr_o | output | 32 | Read word address |
| rd_valid_i | input | 1 | Read completes this cycle |
| rd_data_i | input | 32 | Read data |
| rd_err_i | input | 1 | Read failed (qualified by rd_valid_i) |
| seg_valid_o | output | 1 | Segment offered to the copy engine |
| seg_src_o | output | 32 | Segment source address |
| seg_dst_o | output | 32 | Segment destination address |
| seg_len_o | output | 26 | Segment byte count |
| seg_kind_o | output | 2 | Transfer type code |
| seg_snoop_o | output | 1 | Snoop enable for the segment |
| seg_done_i | input | 1 | Copy engine finished the segment |
| busy_o | output | 1 | Chain in progress |
| eos_o | output | 1 | End-of-segment flag |
| eoc_o | output | 1 | End-of-chain flag |
| lme_o | output | 1 | Memory read error flag |

## Verification
The tests cover five patterns:
- A single-descriptor chain with junk in the low address bits and high count bits set. It shows that alignment masking, the 26-bit count and every flag-to-field mapping are right.
- A three-descriptor chain with a zero-count middle entry and slow memory. It separates link following from segment skipping, and shows that a held request is consumed exactly once.
- A finished chain followed by a continue. It shows that the resume address comes from the stored link rather than cda_i, and that flags clear on acceptance.
- Pulses sent in direct mode and while busy. They tell whether ignored commands leak through.
- An error injected on the third word. It tells an abort apart from a normal completion.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOAD,
    ST_RUN,
    ST_NEXT,
    ST_DONE
  } dcs_state_e;

  // descriptor word slots, in memory order
  localparam int WI_SRC  = 0;
  localparam int WI_DST  = 1;
  localparam int WI_LINK = 2;
  localparam int WI_CNT  = 3;
  localparam int DESC_WORDS = 4;

  // flag bits inside the link word
  localparam int LK_LAST  = 0;
  localparam int LK_KIND  = 1;
  localparam int LK_SIE   = 3;
  localparam int LK_SNOOP = 4;

  // sticky status flag slots
  localparam int FLG_EOS = 0;
  localparam int FLG_EOC = 1;
  localparam int FLG_LME = 2;
  localparam int FLG_N   = 3;

endpackage

// File: rtl/dcs_fetch.sv
module dcs_fetch #(
  parameter int AW        = 32,
  parameter int NWORDS    = 4,
  parameter int STRIDE_LG = 3,
  parameter int ALIGN_LG  = 5
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         launch_i,
  input  logic [AW-ALIGN_LG-1:0]       base_i,
  output logic                         rd_req_o,
  output logic [AW-1:0]                rd_addr_o,
  input  logic                         rd_valid_i,
  input  logic [AW-1:0]                rd_data_i,
  input  logic                         rd_err_i,
  output logic                         done_o,
  output logic                         err_o,
  output logic [NWORDS-1:0][AW-1:0]    words_o
);
  localparam int BASE_W = AW - ALIGN_LG;
  localparam int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NWORDS - 1);

  logic [BASE_W-1:0] base_q;
  logic [IDX_W-1:0]  idx_q;
  logic              req_q;
  logic              done_q;
  logic              err_q;
  logic              take;

  assign take = req_q && rd_valid_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      idx_q  <= '0;
      req_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (launch_i) begin
        base_q <= base_i;
        idx_q  <= '0;
        req_q  <= 1'b1;
      end else if (take) begin
        if (rd_err_i) begin
          req_q <= 1'b0;
          err_q <= 1'b1;
        end else if (idx_q == IDX_LAST) begin
          req_q  <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        words_o[g] <= '0;
      else if (take && !rd_err_i && idx_q == IDX_W'(g))
        words_o[g] <= rd_data_i;
    end
  end

  assign rd_req_o  = req_q;
  assign rd_addr_o = {base_q, {ALIGN_LG{1'b0}}} + (AW'(idx_q) << STRIDE_LG);
  assign done_o    = done_q;
  assign err_o     = err_q;

endmodule

// File: rtl/dcs_status.sv
module dcs_status #(
  parameter int NF = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic [NF-1:0] set_i,
  output logic [NF-1:0] flag_o
);
  for (genvar g = 0; g < NF; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        flag_o[g] <= 1'b0;
      else if (clr_i)
        flag_o[g] <= 1'b0;
      else if (set_i[g])
        flag_o[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/dcs_ctrl.sv
module dcs_ctrl
  import dcs_pkg::*;
#(
  parameter int AW       = 32,
  parameter int CNT_W    = 26,
  parameter int ALIGN_LG = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start_i,
  input  logic                          cont_i,
  input  logic                          direct_i,
  input  logic [AW-1:0]                 cda_i,
  input  logic                          fetch_done_i,
  input  logic                          fetch_err_i,
  input  logic [DESC_WORDS-1:0][AW-1:0] words_i,
  output logic                          launch_o,
  output logic [AW-ALIGN_LG-1:0]        base_o,
  output logic                          busy_o,
  output logic                          seg_valid_o,
  output logic [AW-1:0]                 seg_src_o,
  output logic [AW-1:0]                 seg_dst_o,
  output logic [CNT_W-1:0]              seg_len_o,
  output logic [1:0]                    seg_kind_o,
  output logic                          seg_snoop_o,
  input  logic                          seg_done_i,
  output logic                          flag_clr_o,
  output logic [FLG_N-1:0]              flag_set_o
);
  dcs_state_e st_q;
  logic       busy_q, vld_q, last_q, sie_q, snoop_q;
  logic [AW-1:0]    src_q, dst_q;
  logic [CNT_W-1:0] len_q;
  logic [1:0]       kind_q;

  logic             acc_start, acc_cont;
  logic [AW-1:0]    link_w;
  logic [CNT_W-1:0] cnt_w;
  logic             unused_bits;

  assign link_w = words_i[WI_LINK];
  assign cnt_w  = words_i[WI_CNT][CNT_W-1:0];
  assign unused_bits = ^{cda_i[ALIGN_LG-1:0], words_i[WI_CNT][AW-1:CNT_W]};

  always_comb begin
    acc_start  = (st_q == ST_IDLE) && !direct_i && start_i;
    acc_cont   = (st_q == ST_IDLE) && !direct_i && cont_i && !start_i;
    launch_o   = acc_start || acc_cont || (st_q == ST_NEXT);
    base_o     = acc_start ? cda_i[AW-1:ALIGN_LG] : link_w[AW-1:ALIGN_LG];
    flag_clr_o = acc_start || acc_cont;
    flag_set_o = '0;
    flag_set_o[FLG_EOS] = (st_q == ST_RUN) && seg_done_i && sie_q;
    flag_set_o[FLG_EOC] = (st_q == ST_DONE);
    flag_set_o[FLG_LME] = (st_q == ST_FETCH) && fetch_err_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      busy_q  <= 1'b0;
      vld_q   <= 1'b0;
      last_q  <= 1'b0;
      sie_q   <= 1'b0;
      snoop_q <= 1'b0;
      src_q   <= '0;
      dst_q   <= '0;
      len_q   <= '0;
      kind_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (acc_start || acc_cont) begin
            st_q   <= ST_FETCH;
            busy_q <= 1'b1;
          end
        end
        ST_FETCH: begin
          if (fetch_err_i) begin
            st_q   <= ST_IDLE;
            busy_q <= 1'b0;
          end else if (fetch_done_i) begin
            st_q <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          src_q   <= words_i[WI_SRC];
          dst_q   <= words_i[WI_DST];
          len_q   <= cnt_w;
          kind_q  <= link_w[LK_KIND +: 2];
          snoop_q <= link_w[LK_SNOOP];
          sie_q   <= link_w[LK_SIE];
          last_q  <= link_w[LK_LAST];
          if (cnt_w == '0) begin
            st_q <= link_w[LK_LAST] ? ST_DONE : ST_NEXT;
          end else begin
            vld_q <= 1'b1;
            st_q  <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (seg_done_i) begin
            vld_q <= 1'b0;
            st_q  <= last_q ? ST_DONE : ST_NEXT;
          end
        end
        ST_NEXT: st_q <= ST_FETCH;
        ST_DONE: begin
          st_q   <= ST_IDLE;
          busy_q <= 1'b0;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = busy_q;
  assign seg_valid_o = vld_q;
  assign seg_src_o   = src_q;
  assign seg_dst_o   = dst_q;
  assign seg_len_o   = len_q;
  assign seg_kind_o  = kind_q;
  assign seg_snoop_o = snoop_q;

endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
  import dcs_pkg::*;
#(
  parameter int AW        = 32,
  parameter int CNT_W     = 26,
  parameter int ALIGN_LG  = 5,
  parameter int STRIDE_LG = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             cont_i,
  input  logic             direct_i,
  input  logic [AW-1:0]    cda_i,
  output logic             rd_req_o,
  output logic [AW-1:0]    rd_addr_o,
  input  logic             rd_valid_i,
  input  logic [AW-1:0]    rd_data_i,
  input  logic             rd_err_i,
  output logic             seg_valid_o,
  output logic [AW-1:0]    seg_src_o,
  output logic [AW-1:0]    seg_dst_o,
  output logic [CNT_W-1:0] seg_len_o,
  output logic [1:0]       seg_kind_o,
  output logic             seg_snoop_o,
  input  logic             seg_done_i,
  output logic             busy_o,
  output logic             eos_o,
  output logic             eoc_o,
  output logic             lme_o
);
  localparam int BASE_W = AW - ALIGN_LG;

  logic                          launch;
  logic [BASE_W-1:0]             base;
  logic                          f_done, f_err;
  logic [DESC_WORDS-1:0][AW-1:0] words;
  logic                          fl_clr;
  logic [FLG_N-1:0]              fl_set, flags;

  dcs_fetch #(
    .AW(AW), .NWORDS(DESC_WORDS), .STRIDE_LG(STRIDE_LG), .ALIGN_LG(ALIGN_LG)
  ) i_fetch (
    .clk(clk), .rst(rst),
    .launch_i(launch), .base_i(base),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i), .rd_err_i(rd_err_i),
    .done_o(f_done), .err_o(f_err), .words_o(words)
  );

  dcs_ctrl #(
    .AW(AW), .CNT_W(CNT_W), .ALIGN_LG(ALIGN_LG)
  ) i_ctrl (
    .clk(clk), .rst(rst),
    .start_i(start_i), .cont_i(cont_i), .direct_i(direct_i), .cda_i(cda_i),
    .fetch_done_i(f_done), .fetch_err_i(f_err), .words_i(words),
    .launch_o(launch), .base_o(base), .busy_o(busy_o),
    .seg_valid_o(seg_valid_o), .seg_src_o(seg_src_o), .seg_dst_o(seg_dst_o),
    .seg_len_o(seg_len_o), .seg_kind_o(seg_kind_o), .seg_snoop_o(seg_snoop_o),
    .seg_done_i(seg_done_i),
    .flag_clr_o(fl_clr), .flag_set_o(fl_set)
  );

  dcs_status #(.NF(FLG_N)) i_status (
    .clk(clk), .rst(rst), .clr_i(fl_clr), .set_i(fl_set), .flag_o(flags)
  );

  assign eos_o = flags[FLG_EOS];
  assign eoc_o = flags[FLG_EOC];
  assign lme_o = flags[FLG_LME];

endmodule

// File: rtl/dcs_checker.sv
module dcs_checker #(
  parameter int AW    = 32,
  parameter int CNT_W = 26
) (
  input logic             clk,
  input logic             rst,
  input logic             direct_i,
  input logic             rd_req_o,
  input logic [AW-1:0]    rd_addr_o,
  input logic             rd_valid_i,
  input logic             seg_valid_o,
  input logic [AW-1:0]    seg_src_o,
  input logic [AW-1:0]    seg_dst_o,
  input logic [CNT_W-1:0] seg_len_o,
  input logic             seg_done_i,
  input logic             busy_o,
  input logic             eos_o,
  input logic             eoc_o,
  input logic             lme_o
);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req_o && !rd_valid_i |=> rd_req_o && $stable(rd_addr_o));

  // R1
  req_busy_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req_o |-> busy_o && (rd_addr_o[2:0] == 3'b000));

  // R2
  seg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    seg_valid_o && !seg_done_i |=> seg_valid_o && $stable(seg_src_o)
      && $stable(seg_dst_o) && $stable(seg_len_o));

  // R3
  eoc_end_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(eoc_o) |-> !busy_o && !seg_valid_o && !lme_o);

  // R4
  eos_seg_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(eos_o) |-> $past(seg_valid_o && seg_done_i));

  // R6
  lme_abort_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lme_o) |-> !busy_o && !rd_req_o && !eoc_o);

  // R8
  direct_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o && direct_i |=> !busy_o);
endmodule

bind dma_chain_seq dcs_checker #(.AW(AW), .CNT_W(CNT_W)) i_dcs_checker (.*);

// File: tb/test_dma_chain_seq.sv
module test_dma_chain_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0, cont_i = 1'b0, direct_i = 1'b0;
  logic [31:0] cda_i = '0;
  logic        rd_req_o;
  logic [31:0] rd_addr_o;
  logic        rd_valid_i = 1'b0;
  logic [31:0] rd_data_i = '0;
  logic        rd_err_i = 1'b0;
  logic        seg_valid_o;
  logic [31:0] seg_src_o, seg_dst_o;
  logic [25:0] seg_len_o;
  logic [1:0]  seg_kind_o;
  logic        seg_snoop_o;
  logic        seg_done_i = 1'b0;
  logic        busy_o, eos_o, eoc_o, lme_o;

  always #5 clk = ~clk;

  dma_chain_seq i_dma_chain_seq (.*);

  int errs = 0, checks = 0;
  int mem_lat = 1, seg_lat = 1;
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic [31:0] mem [0:255];

  int rd_n = 0, seg_n = 0;
  logic [31:0] rd_log [0:255];
  logic [31:0] sl_src [0:31];
  logic [31:0] sl_dst [0:31];
  logic [25:0] sl_len [0:31];
  logic [1:0]  sl_kind [0:31];
  logic        sl_snp [0:31];

  int lcnt = 0, scnt = 0;

  // memory model: completes a held request after mem_lat idle cycles
  always @(negedge clk) begin
    if (rst) begin
      rd_valid_i = 1'b0; lcnt = 0;
    end else if (rd_valid_i) begin
      rd_valid_i = 1'b0; rd_err_i = 1'b0; lcnt = 0;
    end else if (rd_req_o) begin
      if (lcnt >= mem_lat) begin
        rd_valid_i = 1'b1;
        rd_data_i  = mem[rd_addr_o[9:2]];
        rd_err_i   = (rd_addr_o == err_addr);
        if (rd_n < 256) rd_log[rd_n] = rd_addr_o;
        rd_n++;
        lcnt = 0;
      end else lcnt++;
    end
  end

  // copy engine model
  always @(negedge clk) begin
    if (rst) begin
      seg_done_i = 1'b0; scnt = 0;
    end else if (seg_done_i) begin
      seg_done_i = 1'b0;
    end else if (seg_valid_o) begin
      if (scnt >= seg_lat) begin
        if (seg_n < 32) begin
          sl_src[seg_n] = seg_src_o; sl_dst[seg_n] = seg_dst_o;
          sl_len[seg_n] = seg_len_o; sl_kind[seg_n] = seg_kind_o;
          sl_snp[seg_n] = seg_snoop_o;
        end
        seg_n++;
        seg_done_i = 1'b1;
        scnt = 0;
      end else scnt++;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  task automatic put_desc(input logic [31:0] at, input logic [31:0] src,
                          input logic [31:0] dst, input logic [31:0] link,
                          input logic [31:0] cnt);
    mem[at[9:2]]       = src;
    mem[at[9:2] + 2]   = dst;
    mem[at[9:2] + 4]   = link;
    mem[at[9:2] + 6]   = cnt;
  endtask

  task automatic pulse_start(input logic [31:0] a);
    @(negedge clk); cda_i = a; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic pulse_cont();
    @(negedge clk); cont_i = 1'b1;
    @(negedge clk); cont_i = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (busy_o && n < 5000) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "busy after reset", {31'd0, busy_o}, 32'd0);
    chk("R1", "rd_req after reset", {31'd0, rd_req_o}, 32'd0);
    chk("R1", "seg_valid after reset", {31'd0, seg_valid_o}, 32'd0);
    chk("R9", "flags after reset", {29'd0, eos_o, eoc_o, lme_o}, 32'd0);
  endtask

  task automatic t_single();
    int r0, s0;
    mem_lat = 1; seg_lat = 1;
    put_desc(32'h40, 32'h1111_0000, 32'h2222_0000, 32'h0000_001D, 32'hFC00_0010);
    r0 = rd_n; s0 = seg_n;
    pulse_start(32'h0000_005F);
    chk("R1", "busy after start", {31'd0, busy_o}, 32'd1);
    wait_idle();
    chk("R1", "read count", rd_n - r0, 32'd4);
    for (int k = 0; k < 4; k++)
      chk("R1", "read address", rd_log[r0 + k], 32'h40 + 32'(k * 8));
    chk("R2", "segment count", seg_n - s0, 32'd1);
    chk("R2", "src", sl_src[s0], 32'h1111_0000);
    chk("R2", "dst", sl_dst[s0], 32'h2222_0000);
    chk("R2", "len 26-bit", {6'd0, sl_len[s0]}, 32'h10);
    chk("R2", "kind", {30'd0, sl_kind[s0]}, 32'd2);
    chk("R2", "snoop", {31'd0, sl_snp[s0]}, 32'd1);
    chk("R4", "eos set", {31'd0, eos_o}, 32'd1);
    chk("R3", "eoc set", {31'd0, eoc_o}, 32'd1);
    chk("R3", "busy low at end", {31'd0, busy_o}, 32'd0);
    chk("R6", "no lme", {31'd0, lme_o}, 32'd0);
  endtask

  task automatic t_chain();
    int r0, s0;
    bit hit;
    mem_lat = 3; seg_lat = 2;
    put_desc(32'h80,  32'h0000_00A0, 32'h0000_00B0, 32'h0000_0100, 32'h0000_0008);
    put_desc(32'h100, 32'h0000_0AAA, 32'h0000_0BBB, 32'h0000_00C0, 32'hFC00_0000);
    put_desc(32'hC0,  32'h0000_00C4, 32'h0000_00D4, 32'h0000_0003, 32'h0000_0004);
    r0 = rd_n; s0 = seg_n;
    pulse_start(32'h80);
    repeat (6) @(negedge clk);
    pulse_start(32'h300);
    pulse_cont();
    wait_idle();
    chk("R10", "reads for three descriptors", rd_n - r0, 32'd12);
    chk("R3", "second descriptor base", rd_log[r0 + 4], 32'h100);
    chk("R3", "third descriptor base", rd_log[r0 + 8], 32'hC0);
    chk("R3", "last read", rd_log[r0 + 11], 32'hD8);
    hit = 1'b0;
    for (int k = r0; k < rd_n; k++) if (rd_log[k][9:5] == 5'h18) hit = 1'b1;
    chk("R11", "start while busy ignored", {31'd0, hit}, 32'd0);
    chk("R5", "zero count skipped", seg_n - s0, 32'd2);
    chk("R2", "first src", sl_src[s0], 32'hA0);
    chk("R5", "second segment is third descriptor", sl_src[s0 + 1], 32'hC4);
    chk("R2", "kind of last", {30'd0, sl_kind[s0 + 1]}, 32'd1);
    chk("R4", "eos stays clear", {31'd0, eos_o}, 32'd0);
    chk("R3", "eoc set", {31'd0, eoc_o}, 32'd1);
  endtask

  task automatic t_continue();
    int r0, s0;
    mem_lat = 0; seg_lat = 0;
    put_desc(32'h180, 32'h0000_00D0, 32'h0000_0D00, 32'h0000_01C1, 32'h0000_0006);
    put_desc(32'h1C0, 32'h0000_00E0, 32'h0000_0E00, 32'h0000_0009, 32'h0000_0007);
    r0 = rd_n; s0 = seg_n;
    pulse_start(32'h180);
    wait_idle();
    chk("R3", "chain of one", seg_n - s0, 32'd1);
    chk("R3", "eoc before continue", {31'd0, eoc_o}, 32'd1);
    pulse_cont();
    chk("R9", "eoc cleared by continue", {31'd0, eoc_o}, 32'd0);
    chk("R7", "busy after continue", {31'd0, busy_o}, 32'd1);
    wait_idle();
    chk("R7", "reads", rd_n - r0, 32'd8);
    chk("R7", "resume address", rd_log[r0 + 4], 32'h1C0);
    chk("R7", "resumed segment src", sl_src[s0 + 1], 32'hE0);
    chk("R4", "eos from resumed", {31'd0, eos_o}, 32'd1);
    chk("R3", "eoc after resume", {31'd0, eoc_o}, 32'd1);
  endtask

  task automatic t_direct();
    int r0, s0;
    r0 = rd_n; s0 = seg_n;
    @(negedge clk); direct_i = 1'b1;
    pulse_start(32'h40);
    pulse_cont();
    repeat (10) @(negedge clk);
    chk("R8", "busy stays low", {31'd0, busy_o}, 32'd0);
    chk("R8", "no reads", rd_n - r0, 32'd0);
    chk("R8", "no segments", seg_n - s0, 32'd0);
    chk("R8", "flags kept", {29'd0, eos_o, eoc_o, lme_o}, 32'b110);
    @(negedge clk); direct_i = 1'b0;
  endtask

  task automatic t_error();
    int r0, s0;
    mem_lat = 1; seg_lat = 1;
    put_desc(32'h200, 32'h0000_0F00, 32'h0000_0F10, 32'h0000_0240, 32'h0000_0005);
    err_addr = 32'h210;
    r0 = rd_n; s0 = seg_n;
    pulse_start(32'h200);
    wait_idle();
    chk("R6", "lme set", {31'd0, lme_o}, 32'd1);
    chk("R6", "eoc low", {31'd0, eoc_o}, 32'd0);
    chk("R6", "reads stop at error", rd_n - r0, 32'd3);
    chk("R6", "no segment", seg_n - s0, 32'd0);
    chk("R6", "busy low", {31'd0, busy_o}, 32'd0);
    err_addr = 32'hFFFF_FFFF;
    pulse_start(32'h40);
    wait_idle();
    chk("R9", "lme cleared by start", {31'd0, lme_o}, 32'd0);
    chk("R9", "eoc after good chain", {31'd0, eoc_o}, 32'd1);
  endtask

  initial begin
    for (int k = 0; k < 256; k++) mem[k] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single();
    t_chain();
    t_continue();
    t_direct();
    t_error();
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end
endmodule